// File: doc/BRIEF.md
# Pulse-Position Downlink Decoder

This block turns a reader-to-tag pause stream into bytes. Its input is a single pause-detect bit, already demodulated and synchronous to a clock that runs at the carrier frequency. Any demodulation depth the front end detects reaches the block as the same pause bit. The decoder uses only the rising edge of each pause. It measures the edge position with a tick counter in slots of `2^SLOT_LOG2` ticks.

Every frame opens with a start pattern, and the spacing of its two pauses selects one of two coding modes. In the byte mode, one pause among 256 slots carries a whole byte. In the pair mode, one pause among 4 slots carries two bits, and four such symbols form a byte with the least significant pair first. A pause in the early half of a slot is a code violation. Data never produces one, so the end-of-frame delimiter is built from it. Malformed symbols abort the frame, and the decoder then waits for a fresh start pattern.

Top module: `ppm_downlink_decoder`

## Requirements
- R1: While reset is asserted, and right after it, every output is zero.
- R2: Tick counting starts at the rising edge of the first pause of a start pattern. A second pause edge falls in slot floor(ticks/SLOT). Slot 2 selects the pair mode (`long_mode_o`=0) and slot 3 selects the byte mode (`long_mode_o`=1). `frame_start_o` pulses in the cycle after tick 4*SLOT-1. Data symbols start one tick later, and `long_mode_o` stays constant while `in_frame_o` is high.
- R3: In byte mode a symbol spans 256 slots. The byte equals the index of the slot that holds the pause. It appears with `data_valid_o` in the cycle after the symbol's last tick, and 0xE1 is decoded as 225.
- R4: In pair mode a symbol spans 4 slots and gives a 2-bit value equal to the slot index. Four symbols form one byte with the first pair in bits 1:0 and the fourth pair in bits 7:6. The byte is emitted after the fourth symbol's last tick, and 0xE1 arrives as slots 1,0,2,3.
- R5: A data pause is valid only with offset within its slot of at least SLOT/2. An early-half pause in any slot other than slot 0 raises `code_err_o`.
- R6: An early-half pause in slot 0 of a symbol that has had no pause yet ends the frame with `frame_end_o`. In pair mode it raises `code_err_o` instead, if the pairs received do not complete a byte.
- R7: A second pause inside one symbol raises `code_err_o` at that pause.
- R8: A symbol that ends without a pause raises `code_err_o` after its last tick.
- R9: A start pattern whose second pause lies outside slots 2 and 3, or that has no second pause within 4 slots, raises `code_err_o`.
- R10: After an error or an end of frame, `in_frame_o` drops and no byte is output until a new valid start pattern. `frame_start_o`, `frame_end_o` and `code_err_o` never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Carrier-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pause_i | input | 1 | Synchronised pause detect, high during a pause |
| data_o | output | 8 | Decoded byte |
| data_valid_o | output | 1 | One-cycle strobe for `data_o` |
| frame_start_o | output | 1 | One-cycle pulse when a start pattern is accepted |
| frame_end_o | output | 1 | One-cycle pulse on a valid end delimiter |
| code_err_o | output | 1 | One-cycle pulse when a frame is aborted |
| long_mode_o | output | 1 | 1 = byte mode, 0 = pair mode |
| in_frame_o | output | 1 | High while data symbols are being decoded |

## Verification
The assertions take for granted that `pause_i` is synchronous to the clock and that each pause is high for at least one tick. They also assume a pause ends before the next slot boundary, so one rising edge stands for one pause. The stimulus uses two-tick pauses placed one tick past a slot start or one tick past a slot's midpoint, with a slot of 8 ticks. No edge therefore sits on a boundary, and every pause is low again well before the next one.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SOF  = 2'd1,
    ST_DATA = 2'd2
  } ppm_state_e;

  // Number of slots a start pattern occupies before data begins.
  localparam int unsigned SOF_SLOTS = 4;

  // True when a tick offset lies in the early half of its slot.
  function automatic bit is_early(input int unsigned tick, input int unsigned sl2);
    return ((tick >> (sl2 - 1)) & 32'd1) == 32'd0;
  endfunction

  // Length of one data symbol in ticks for the selected mode.
  function automatic int unsigned symbol_ticks(input bit byte_mode, input int unsigned sl2);
    return (byte_mode ? 32'd256 : 32'd4) << sl2;
  endfunction

  // Shift a new bit pair in at the top; the oldest pair ends up in bits 1:0.
  function automatic logic [7:0] merge_pair(input logic [7:0] acc, input logic [1:0] pair);
    return {pair, acc[7:2]};
  endfunction

endpackage

// File: rtl/ppm_pause_edge.sv
module ppm_pause_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pause_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pause_i;
  end

  assign edge_o = pause_i & ~prev_q;
endmodule

// File: rtl/ppm_tick_timer.sv
module ppm_tick_timer #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  output logic [WIDTH-1:0] tick_o
);
  logic [WIDTH-1:0] tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tick_q <= '0;
    else if (clear_i) tick_q <= '0;
    else              tick_q <= tick_q + 1'b1;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/ppm_pair_packer.sv
module ppm_pair_packer
  import ppm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       push_i,
  input  logic [1:0] pair_i,
  output logic [1:0] count_o,
  output logic       last_o,
  output logic [7:0] merged_o
);
  logic [7:0] acc_q;
  logic [1:0] cnt_q;

  assign merged_o = merge_pair(acc_q, pair_i);
  assign last_o   = (cnt_q == 2'd3);
  assign count_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (push_i) begin
      acc_q <= merged_o;
      cnt_q <= cnt_q + 2'd1;
    end
  end
endmodule

// File: rtl/ppm_downlink_decoder.sv
module ppm_downlink_decoder
  import ppm_pkg::*;
#(
  parameter int unsigned SLOT_LOG2 = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pause_i,
  output logic [7:0] data_o,
  output logic       data_valid_o,
  output logic       frame_start_o,
  output logic       frame_end_o,
  output logic       code_err_o,
  output logic       long_mode_o,
  output logic       in_frame_o
);
  localparam int unsigned TICK_W   = SLOT_LOG2 + 8;
  localparam int unsigned SOF_LAST = (SOF_SLOTS << SLOT_LOG2) - 1;

  ppm_state_e state_q, state_d;
  logic       seen_q, seen_d;
  logic       got_q, got_d;
  logic [7:0] val_q, val_d;
  logic       mode_q, mode_d;
  logic [7:0] data_q, data_d;
  logic       valid_q, valid_d, start_q, start_d, end_q, end_d, err_q, err_d;

  logic              edge_w, early_w, sym_last_w, sof_last_w, clear_tick, push, abort;
  logic [TICK_W-1:0] tick_w;
  logic [7:0]        slot_w, sym_val_w, pk_merged;
  logic [1:0]        pk_cnt;
  logic              pk_last, pk_clear;

  ppm_pause_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pause_i(pause_i),
    .edge_o (edge_w)
  );

  ppm_tick_timer #(.WIDTH(TICK_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_tick),
    .tick_o (tick_w)
  );

  assign pk_clear = (state_q != ST_DATA);

  ppm_pair_packer i_packer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (pk_clear),
    .push_i  (push),
    .pair_i  (sym_val_w[1:0]),
    .count_o (pk_cnt),
    .last_o  (pk_last),
    .merged_o(pk_merged)
  );

  assign slot_w     = tick_w[TICK_W-1:SLOT_LOG2];
  assign early_w    = is_early(32'(tick_w), SLOT_LOG2);
  assign sym_last_w = (32'(tick_w) == symbol_ticks(mode_q, SLOT_LOG2) - 32'd1);
  assign sof_last_w = (32'(tick_w) == SOF_LAST);
  assign sym_val_w  = edge_w ? slot_w : val_q;

  always_comb begin
    state_d    = state_q;
    seen_d     = seen_q;
    got_d      = got_q;
    val_d      = val_q;
    mode_d     = mode_q;
    data_d     = data_q;
    valid_d    = 1'b0;
    start_d    = 1'b0;
    end_d      = 1'b0;
    err_d      = 1'b0;
    push       = 1'b0;
    clear_tick = 1'b0;
    abort      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (edge_w) begin
          state_d = ST_SOF;
          seen_d  = 1'b0;
        end else begin
          clear_tick = 1'b1;
        end
      end
      ST_SOF: begin
        if (edge_w && (seen_q || !(slot_w == 8'd2 || slot_w == 8'd3))) begin
          abort = 1'b1;
        end else if (sof_last_w) begin
          if (seen_q || edge_w) begin
            state_d    = ST_DATA;
            start_d    = 1'b1;
            got_d      = 1'b0;
            clear_tick = 1'b1;
            if (edge_w) mode_d = (slot_w == 8'd3);
          end else begin
            abort = 1'b1;
          end
        end else if (edge_w) begin
          seen_d = 1'b1;
          mode_d = (slot_w == 8'd3);
        end
      end
      ST_DATA: begin
        if (edge_w && early_w) begin
          if (slot_w == 8'd0 && !got_q) begin
            if (!mode_q && pk_cnt != 2'd0) begin
              abort = 1'b1;
            end else begin
              end_d      = 1'b1;
              state_d    = ST_IDLE;
              clear_tick = 1'b1;
            end
          end else begin
            abort = 1'b1;
          end
        end else if (edge_w && got_q) begin
          abort = 1'b1;
        end else if (sym_last_w) begin
          if (!(got_q || edge_w)) begin
            abort = 1'b1;
          end else begin
            got_d      = 1'b0;
            clear_tick = 1'b1;
            if (mode_q) begin
              valid_d = 1'b1;
              data_d  = sym_val_w;
            end else begin
              push = 1'b1;
              if (pk_last) begin
                valid_d = 1'b1;
                data_d  = pk_merged;
              end
            end
          end
        end else if (edge_w) begin
          got_d = 1'b1;
          val_d = slot_w;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort) begin
      err_d      = 1'b1;
      state_d    = ST_IDLE;
      got_d      = 1'b0;
      clear_tick = 1'b1;
      push       = 1'b0;
      valid_d    = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      seen_q  <= 1'b0;
      got_q   <= 1'b0;
      val_q   <= '0;
      mode_q  <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
      start_q <= 1'b0;
      end_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      seen_q  <= seen_d;
      got_q   <= got_d;
      val_q   <= val_d;
      mode_q  <= mode_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      start_q <= start_d;
      end_q   <= end_d;
      err_q   <= err_d;
    end
  end

  assign data_o        = data_q;
  assign data_valid_o  = valid_q;
  assign frame_start_o = start_q;
  assign frame_end_o   = end_q;
  assign code_err_o    = err_q;
  assign long_mode_o   = mode_q;
  assign in_frame_o    = (state_q == ST_DATA);
endmodule

// File: rtl/ppm_downlink_decoder_chk.sv
module ppm_downlink_decoder_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic frame_start_i,
  input logic frame_end_i,
  input logic code_err_i,
  input logic data_valid_i,
  input logic in_frame_i,
  input logic long_mode_i,
  input logic pause_edge_i,
  input logic early_i,
  input logic sym_last_i,
  input logic sym_has_pause_i
);
  assert_flags_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({frame_start_i, frame_end_i, code_err_i}));

  assert_err_leaves_frame_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_err_i |-> !in_frame_i);

  assert_entry_needs_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_frame_i) |-> frame_start_i);

  assert_end_leaves_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |-> !in_frame_i);

  assert_start_enters_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |-> in_frame_i);

  assert_mode_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame_i && $past(in_frame_i)) |-> $stable(long_mode_i));

  assert_byte_in_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_i |-> (in_frame_i && !code_err_i));

  assert_double_pause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame_i && sym_has_pause_i && pause_edge_i && !early_i) |=> code_err_i);

  assert_missing_pause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame_i && sym_last_i && !sym_has_pause_i && !pause_edge_i) |=> code_err_i);
endmodule

bind ppm_downlink_decoder ppm_downlink_decoder_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .frame_start_i  (frame_start_o),
  .frame_end_i    (frame_end_o),
  .code_err_i     (code_err_o),
  .data_valid_i   (data_valid_o),
  .in_frame_i     (in_frame_o),
  .long_mode_i    (long_mode_o),
  .pause_edge_i   (edge_w),
  .early_i        (early_w),
  .sym_last_i     (sym_last_w),
  .sym_has_pause_i(got_q)
);

// File: tb/test_ppm_downlink_decoder.sv
module test_ppm_downlink_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int SL2 = 3;
  localparam int S = 1 << SL2;
  localparam int H = S / 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pause_i = 1'b0;
  logic [7:0] data_o;
  logic       data_valid_o, frame_start_o, frame_end_o, code_err_o, long_mode_o, in_frame_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ppm_downlink_decoder #(.SLOT_LOG2(SL2)) i_ppm_downlink_decoder (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .pause_i      (pause_i),
    .data_o       (data_o),
    .data_valid_o (data_valid_o),
    .frame_start_o(frame_start_o),
    .frame_end_o  (frame_end_o),
    .code_err_o   (code_err_o),
    .long_mode_o  (long_mode_o),
    .in_frame_o   (in_frame_o)
  );

  int checks = 0;
  int fails  = 0;
  int t      = 20;

  bit         pause_plan[int];
  string      ex_start[int];
  bit         ex_mode[int];
  string      ex_end[int];
  string      ex_err[int];
  logic [7:0] ex_byte[int];
  string      ex_btag[int];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic pulse(input int c);
    pause_plan[c]     = 1'b1;
    pause_plan[c + 1] = 1'b1;
  endtask

  task automatic sof(input bit longm, input string tag);
    pulse(t);
    pulse(t + (longm ? 3 : 2) * S + 1);
    ex_start[t + 4 * S - 1] = tag;
    ex_mode[t + 4 * S - 1]  = longm;
    t += 4 * S;
  endtask

  task automatic sym4(input int p);
    pulse(t + p * S + H + 1);
    t += 4 * S;
  endtask

  task automatic byte4(input logic [7:0] b, input string tag);
    for (int i = 0; i < 4; i++) sym4((int'(b) >> (2 * i)) & 3);
    ex_byte[t - 1] = b;
    ex_btag[t - 1] = tag;
  endtask

  task automatic byte256(input logic [7:0] b, input string tag);
    pulse(t + int'(b) * S + H + 1);
    t += 256 * S;
    ex_byte[t - 1] = b;
    ex_btag[t - 1] = tag;
  endtask

  task automatic eof(input string tag);
    pulse(t + 1);
    ex_end[t + 1] = tag;
    t += 2 * S;
  endtask

  task automatic build_plan();
    // R4 / R6: pair-mode frame, least significant pair first, clean end
    sof(1'b0, "R2");
    byte4(8'hE1, "R4");
    byte4(8'h00, "R4");
    byte4(8'hFF, "R4");
    byte4(8'h5A, "R4");
    eof("R6");
    // R3: byte-mode frame including the extreme positions
    sof(1'b1, "R2");
    byte256(8'hE1, "R3");
    byte256(8'h00, "R3");
    byte256(8'hFF, "R3");
    eof("R6");
    // R6: end delimiter after two pairs only is an error
    sof(1'b0, "R2");
    byte4(8'h36, "R4");
    sym4(1);
    sym4(2);
    pulse(t + 1);
    ex_err[t + 1] = "R6";
    t += 2 * S;
    // R7: two pauses within one symbol
    sof(1'b0, "R2");
    pulse(t + H + 1);
    pulse(t + 2 * S + H + 1);
    ex_err[t + 2 * S + H + 1] = "R7";
    t += 4 * S + 2 * S;
    // R5: early-half pause in slot 2
    sof(1'b0, "R2");
    pulse(t + 2 * S + 1);
    ex_err[t + 2 * S + 1] = "R5";
    t += 4 * S + 2 * S;
    // R10: a stray data-like pause after an abort is not data
    pulse(t + 3 * S + H + 1);
    ex_err[t + 3 * S + H + 1 + 4 * S - 1] = "R10";
    t += 8 * S + 2 * S;
    // R8: byte-mode symbol without a pause
    sof(1'b1, "R2");
    byte256(8'h10, "R3");
    ex_err[t + 256 * S - 1] = "R8";
    t += 256 * S + 2 * S;
    // R9: second start pause in slot 1
    pulse(t);
    pulse(t + S + 1);
    ex_err[t + S + 1] = "R9";
    t += 4 * S + 2 * S;
    // R9: start pattern with no second pause
    pulse(t);
    ex_err[t + 4 * S - 1] = "R9";
    t += 4 * S + 2 * S;
    // R6 / R10: empty byte-mode frame, then a pair-mode frame resynchronises
    sof(1'b1, "R2");
    eof("R6");
    sof(1'b0, "R10");
    byte4(8'hE1, "R4");
    eof("R6");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit exp_in;
    bit exp_mode;
    int t_end;
    exp_in   = 1'b0;
    exp_mode = 1'b0;
    build_plan();
    t_end = t + 16;
    for (int c = 0; c <= t_end; c++) begin
      @(posedge clk);
      #(CLK_PERIOD / 2);
      if (c < 3) begin
        chk({data_o, data_valid_o, frame_start_o, frame_end_o, code_err_o, long_mode_o, in_frame_o} == '0,
            "R1", "outputs in reset", int'({data_valid_o, frame_start_o, frame_end_o, code_err_o}), 0);
      end else begin
        bit s, e, r, v;
        s = ex_start.exists(c);
        e = ex_end.exists(c);
        r = ex_err.exists(c);
        v = ex_byte.exists(c);
        if (s) begin
          exp_in   = 1'b1;
          exp_mode = ex_mode[c];
        end
        if (e || r) exp_in = 1'b0;
        chk(frame_start_o == s, s ? ex_start[c] : "R10", "frame_start", int'(frame_start_o), int'(s));
        chk(frame_end_o == e, e ? ex_end[c] : "R6", "frame_end", int'(frame_end_o), int'(e));
        chk(code_err_o == r, r ? ex_err[c] : "R10", "code_err", int'(code_err_o), int'(r));
        chk(data_valid_o == v, v ? ex_btag[c] : "R10", "data_valid", int'(data_valid_o), int'(v));
        if (v && data_valid_o) chk(data_o == ex_byte[c], ex_btag[c], "data", int'(data_o), int'(ex_byte[c]));
        chk(in_frame_o == exp_in, "R10", "in_frame", int'(in_frame_o), int'(exp_in));
        if (exp_in) chk(long_mode_o == exp_mode, "R2", "long_mode", int'(long_mode_o), int'(exp_mode));
      end
      pause_i = pause_plan.exists(c + 1);
      rst_ni  = (c + 1 >= 3);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule